// File: doc/BRIEF.md
# Burst Element-wise Vector Multiplier

This block reads two vectors of signed 32-bit integers from memory, multiplies them element by element, and writes the products back to a third buffer. It reaches memory through a single master port with AXI4 burst semantics. Three byte base addresses and a start strobe arrive on plain register inputs. A one-cycle done strobe reports that the result buffer has been written and that its write response has come back.

After start, the controller word-aligns the three bases. It puts two incrementing read bursts on the read-address channel, the first for the left-operand vector and the second for the right-operand vector, and one write burst on the write-address channel. The first read burst fills a small operand buffer. The beats of the second read burst then flow through a four-stage loop that accepts one element per clock: index and exit test, operand pairing, multiply, and write beat. Back-pressure on write data freezes the whole loop. The block waits for the write response before it reports done.

Top module: `vec_burst_mul`

## Requirements
- R1: Every read and write burst address is the matching base address with its two low bits forced to zero. The left-operand read uses the A base, the right-operand read uses the B base and the write uses the result base.
- R2: Each read and write burst asks for 8 beats (length field 7), a beat size of 4 bytes (size code 2) and an incrementing burst (burst code 1).
- R3: The left-operand read burst is requested before the right-operand read burst, and each run issues exactly two read requests and one write request.
- R4: Result word i, stored at the aligned result base plus 4*i, equals the low 32 bits of the signed product of operand word i from A and operand word i from B. Overflow wraps.
- R5: Every write beat has all four byte strobes set, and the last-beat flag is set on the eighth beat only.
- R6: With no back-pressure, the product of a right-operand beat is offered and accepted on the write-data channel 3 cycles after that beat is accepted, and the eight write beats take eight consecutive cycles.
- R7: While write data is valid but not ready, the write data and last flag hold steady and no read beat is accepted. Read and write address requests also hold until accepted.
- R8: Done rises in the cycle after the write-response handshake and lasts exactly one cycle per run.
- R9: A start strobe while a run is in progress is ignored: it adds no requests and does not change the addresses or results of that run.
- R10: While reset is asserted, every valid and ready output and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (taken only when idle) |
| base_a | input | 32 | Byte address of the left-operand vector |
| base_b | input | 32 | Byte address of the right-operand vector |
| base_r | input | 32 | Byte address of the result vector |
| done | output | 1 | One-cycle completion strobe |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read burst address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rlast | input | 1 | Last read beat |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write burst address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
A product is due on the write-data channel 3 cycles after its right-operand read beat is accepted, and done is due 1 cycle after the write-response handshake. The memory model in the bench logs the cycle of every handshake, and the bench compares those cycle differences exactly in a run with no back-pressure. In runs with random back-pressure, only order and data are compared, because the stalls shift the timing. All outputs are sampled on the falling edge, so every register stage between an accepted input and the output it drives has settled.

// File: rtl/vmb_pkg.sv
`timescale 1ns/1ps
package vmb_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_VEC_LEN = 8;
  localparam int unsigned DEF_LEN_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_A,
    ST_ADDR_B,
    ST_FILL,
    ST_STREAM,
    ST_RESP,
    ST_DONE
  } vmb_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/vmb_abuf.sv
`timescale 1ns/1ps
module vmb_abuf #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (we && widx == IDX_W'(s)) slot_q[s] <= wdata;
    end
  end

  assign rdata = slot_q[ridx[SEL_W-1:0]];
endmodule

// File: rtl/vmb_ctrl.sv
`timescale 1ns/1ps
module vmb_ctrl
  import vmb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned STRB_W  = 4,
  parameter int unsigned VEC_LEN = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [ADDR_W-1:0] base_r,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  input  logic              r_valid,
  output logic              fill_ready,
  output logic              fill_we,
  output logic [IDX_W-1:0]  fill_idx,
  output logic              stream_go,
  output logic              pipe_clr,
  input  logic              w_done,
  input  logic              b_valid,
  output logic              b_ready,
  output logic              done
);
  function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(STRB_W - 1);
  endfunction

  vmb_state_e        st_q, st_d;
  logic [ADDR_W-1:0] pa_q, pb_q, pr_q;
  logic              aw_pend_q;
  logic [IDX_W-1:0]  fill_q;
  logic              take_start;
  logic              fill_last;

  assign take_start = (st_q == ST_IDLE) && start;
  assign fill_last  = fill_we && (fill_q == IDX_W'(VEC_LEN - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start)     st_d = ST_ADDR_A;
      ST_ADDR_A: if (ar_ready)  st_d = ST_ADDR_B;
      ST_ADDR_B: if (ar_ready)  st_d = ST_FILL;
      ST_FILL:   if (fill_last) st_d = ST_STREAM;
      ST_STREAM: if (w_done)    st_d = ST_RESP;
      ST_RESP:   if (b_valid)   st_d = ST_DONE;
      ST_DONE:                  st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      aw_pend_q <= 1'b0;
      fill_q    <= '0;
    end else begin
      st_q <= st_d;
      if (take_start)                aw_pend_q <= 1'b1;
      else if (aw_pend_q && aw_ready) aw_pend_q <= 1'b0;
      if (st_q == ST_IDLE) fill_q <= '0;
      else if (fill_we)    fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_start) begin
      pa_q <= align_word(base_a);
      pb_q <= align_word(base_b);
      pr_q <= align_word(base_r);
    end
  end

  assign ar_valid   = (st_q == ST_ADDR_A) || (st_q == ST_ADDR_B);
  assign ar_addr    = (st_q == ST_ADDR_B) ? pb_q : pa_q;
  assign aw_valid   = aw_pend_q;
  assign aw_addr    = pr_q;
  assign fill_ready = (st_q == ST_FILL);
  assign fill_we    = fill_ready && r_valid;
  assign fill_idx   = fill_q;
  assign stream_go  = (st_q == ST_STREAM);
  assign pipe_clr   = (st_q == ST_IDLE);
  assign b_ready    = (st_q == ST_RESP);
  assign done       = (st_q == ST_DONE);
endmodule

// File: rtl/vmb_pipe.sv
`timescale 1ns/1ps
module vmb_pipe #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned VEC_LEN = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              go,
  input  logic              r_valid,
  input  logic [DATA_W-1:0] r_data,
  output logic              r_ready,
  output logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_word,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DATA_W-1:0] w_data,
  output logic              w_last,
  output logic              w_done,
  output logic              stall
);
  function automatic logic [DATA_W-1:0] mul_wrap(input logic signed [DATA_W-1:0] x,
                                                  input logic signed [DATA_W-1:0] y);
    logic signed [2*DATA_W-1:0] full;
    full = (2*DATA_W)'(x) * (2*DATA_W)'(y);
    return full[DATA_W-1:0];
  endfunction

  logic [IDX_W-1:0]  cnt_q;
  logic              v1_q, v2_q, v3_q;
  logic              l1_q, l2_q, l3_q;
  logic [DATA_W-1:0] a1_q, b1_q, p2_q, d3_q;
  logic              at_end, take;

  assign stall   = v3_q && !w_ready;
  assign at_end  = (cnt_q == IDX_W'(VEC_LEN));
  assign r_ready = go && !at_end && !stall;
  assign take    = r_valid && r_ready;
  assign a_idx   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
    end else if (!stall) begin
      if (take) cnt_q <= cnt_q + 1'b1;
      v1_q <= take;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!stall) begin
      a1_q <= a_word;
      b1_q <= r_data;
      l1_q <= (cnt_q == IDX_W'(VEC_LEN - 1));
      p2_q <= mul_wrap(a1_q, b1_q);
      l2_q <= l1_q;
      d3_q <= p2_q;
      l3_q <= l2_q;
    end
  end

  assign w_valid = v3_q;
  assign w_data  = d3_q;
  assign w_last  = v3_q && l3_q;
  assign w_done  = v3_q && w_ready && l3_q;
endmodule

// File: rtl/vec_burst_mul.sv
`timescale 1ns/1ps
module vec_burst_mul
  import vmb_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned VEC_LEN = DEF_VEC_LEN,
  parameter int unsigned LEN_W   = DEF_LEN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_a,
  input  logic [ADDR_W-1:0]   base_b,
  input  logic [ADDR_W-1:0]   base_r,
  output logic                done,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [LEN_W-1:0]    m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic                m_rlast,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned SIZE_C = $clog2(STRB_W);
  localparam int unsigned IDX_W  = $clog2(VEC_LEN) + 1;

  logic              fill_ready, fill_we, stream_go, pipe_clr;
  logic [IDX_W-1:0]  fill_idx, a_idx;
  logic [DATA_W-1:0] a_word;
  logic              pipe_rready, w_done;

  // named events for the checker
  logic ev_ar_hs, ev_r_hs, ev_w_hs, ev_b_hs, ev_stall;
  logic unused_in;

  vmb_ctrl #(
    .ADDR_W(ADDR_W), .STRB_W(STRB_W), .VEC_LEN(VEC_LEN), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .base_a(base_a), .base_b(base_b), .base_r(base_r),
    .ar_valid(m_arvalid), .ar_ready(m_arready), .ar_addr(m_araddr),
    .aw_valid(m_awvalid), .aw_ready(m_awready), .aw_addr(m_awaddr),
    .r_valid(m_rvalid), .fill_ready(fill_ready), .fill_we(fill_we),
    .fill_idx(fill_idx), .stream_go(stream_go), .pipe_clr(pipe_clr),
    .w_done(w_done), .b_valid(m_bvalid), .b_ready(m_bready), .done(done)
  );

  vmb_abuf #(
    .DATA_W(DATA_W), .DEPTH(VEC_LEN), .IDX_W(IDX_W)
  ) u_abuf (
    .clk(clk), .we(fill_we), .widx(fill_idx), .wdata(m_rdata),
    .ridx(a_idx), .rdata(a_word)
  );

  vmb_pipe #(
    .DATA_W(DATA_W), .VEC_LEN(VEC_LEN), .IDX_W(IDX_W)
  ) u_pipe (
    .clk(clk), .rst(rst), .clr(pipe_clr), .go(stream_go),
    .r_valid(m_rvalid), .r_data(m_rdata), .r_ready(pipe_rready),
    .a_idx(a_idx), .a_word(a_word),
    .w_valid(m_wvalid), .w_ready(m_wready), .w_data(m_wdata),
    .w_last(m_wlast), .w_done(w_done), .stall(ev_stall)
  );

  assign m_rready  = fill_ready | pipe_rready;
  assign m_wstrb   = '1;
  assign m_arlen   = LEN_W'(VEC_LEN - 1);
  assign m_awlen   = LEN_W'(VEC_LEN - 1);
  assign m_arsize  = 3'(SIZE_C);
  assign m_awsize  = 3'(SIZE_C);
  assign m_arburst = BURST_INCR;
  assign m_awburst = BURST_INCR;

  assign ev_ar_hs  = m_arvalid && m_arready;
  assign ev_r_hs   = m_rvalid && m_rready;
  assign ev_w_hs   = m_wvalid && m_wready;
  assign ev_b_hs   = m_bvalid && m_bready;
  assign unused_in = m_rlast ^ (^m_bresp);
endmodule

// File: rtl/vec_burst_mul_chk.sv
`timescale 1ns/1ps
module vec_burst_mul_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_rready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wlast,
  input logic              ev_b_hs
);
  a_r1_ar_aligned: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> m_araddr[1:0] == 2'b00);
  a_r1_aw_aligned: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> m_awaddr[1:0] == 2'b00);
  a_r7_w_hold: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));
  a_r7_no_read_on_stall: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |-> !m_rready);
  a_r7_ar_hold: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
  a_r7_aw_hold: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  a_r8_done_after_resp: assert property (@(posedge clk) disable iff (rst)
    ev_b_hs |=> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind vec_burst_mul vec_burst_mul_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_vec_burst_mul.sv
`timescale 1ns/1ps
module test_vec_burst_mul;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] base_a = '0, base_b = '0, base_r = '0;
  logic done;
  logic m_arvalid, m_arready = 1'b0;
  logic [31:0] m_araddr;
  logic [7:0] m_arlen, m_awlen;
  logic [2:0] m_arsize, m_awsize;
  logic [1:0] m_arburst, m_awburst;
  logic m_rvalid = 1'b0, m_rready, m_rlast = 1'b0;
  logic [31:0] m_rdata = '0;
  logic m_awvalid, m_awready = 1'b0;
  logic [31:0] m_awaddr;
  logic m_wvalid, m_wready = 1'b0, m_wlast;
  logic [31:0] m_wdata;
  logic [3:0] m_wstrb;
  logic m_bvalid = 1'b0, m_bready;
  logic [1:0] m_bresp = 2'b00;

  always #2 clk = ~clk;

  vec_burst_mul i_vec_burst_mul (.*);

  // stimulus table: bases, seeds/steps of both vectors, back-pressure
  localparam logic [31:0] T_BA [4] = '{32'h00, 32'h21, 32'hC0, 32'h80};
  localparam logic [31:0] T_BB [4] = '{32'h40, 32'h63, 32'h00, 32'hE0};
  localparam logic [31:0] T_BR [4] = '{32'h80, 32'hA2, 32'h43, 32'h20};
  localparam logic [31:0] T_SA [4] = '{32'h1, 32'hFFFF_FFFB, 32'h7FFF_FFF0, 32'h8000_0000};
  localparam logic [31:0] T_DA [4] = '{32'h1, 32'h7, 32'h0100_0000, 32'h1};
  localparam logic [31:0] T_SB [4] = '{32'h2, 32'd100, 32'h4000_0001, 32'hFFFF_FFFF};
  localparam logic [31:0] T_DB [4] = '{32'h3, 32'hFFFF_FFC0, 32'h1357_9BDF, 32'h2};
  localparam bit          T_BP [4] = '{1'b0, 1'b1, 1'b1, 1'b1};

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [31:0] mem [64];
  bit bp = 1'b0;

  // memory model state
  int ar_cnt, rserved, rbeat, aw_cnt, wcnt, fmt_err, w_err, stab_err, done_cnt;
  logic [31:0] ar_log [4];
  logic [31:0] aw_log;
  logic [31:0] wbuf [8];
  bit b_sent;
  int rb0_cyc, w0_cyc, w7_cyc, b_cyc, done_cyc;
  bit hs_ar, hs_r, hs_aw, hs_w, hs_b, w_wait;
  logic [31:0] w_prev;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    ar_cnt = 0; rserved = 0; rbeat = 0; aw_cnt = 0; wcnt = 0;
    fmt_err = 0; w_err = 0; stab_err = 0; done_cnt = 0; b_sent = 1'b0;
    rb0_cyc = -100; w0_cyc = 0; w7_cyc = 0; b_cyc = 0; done_cyc = 0;
    w_wait = 1'b0;
  endtask

  function automatic bit rnd(input bit pressure);
    return pressure ? bit'($urandom % 2) : 1'b1;
  endfunction

  // behavioural memory: acts on handshakes seen before the last rising edge
  initial begin
    model_clear();
    hs_ar = 0; hs_r = 0; hs_aw = 0; hs_w = 0; hs_b = 0;
    forever begin
      @(negedge clk);
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (hs_ar) begin
        if (ar_cnt < 4) ar_log[ar_cnt] = m_araddr_q;
        ar_cnt++;
      end
      if (hs_r) begin
        rbeat++;
        if (rbeat == 8) begin rbeat = 0; rserved++; end
      end
      if (hs_aw) begin aw_log = m_awaddr_q; aw_cnt++; end
      if (hs_w) begin
        if (wcnt < 8) wbuf[wcnt] = m_wdata_q;
        wcnt++;
      end
      if (hs_b) begin
        for (int i = 0; i < 8; i++) mem[((aw_log >> 2) + i) & 63] = wbuf[i];
        b_sent = 1'b1;
      end
      if (rst) begin
        m_arready = 0; m_rvalid = 0; m_awready = 0; m_wready = 0; m_bvalid = 0;
      end else begin
        m_arready = rnd(bp);
        m_awready = rnd(bp);
        m_wready  = rnd(bp);
        if (!(m_rvalid && !hs_r)) m_rvalid = (ar_cnt > rserved) && rnd(bp);
        if (ar_cnt > rserved && rserved < 4) begin
          m_rdata = mem[((ar_log[rserved] >> 2) + rbeat) & 63];
          m_rlast = (rbeat == 7);
        end
        if (!(m_bvalid && !hs_b))
          m_bvalid = (aw_cnt > 0) && (wcnt == 8) && !b_sent && rnd(bp);
      end
      #1;
      hs_ar = m_arvalid && m_arready;
      hs_r  = m_rvalid && m_rready;
      hs_aw = m_awvalid && m_awready;
      hs_w  = m_wvalid && m_wready;
      hs_b  = m_bvalid && m_bready;
      m_araddr_q = m_araddr;
      m_awaddr_q = m_awaddr;
      m_wdata_q  = m_wdata;
      if (hs_ar && (m_arlen != 8'd7 || m_arsize != 3'd2 || m_arburst != 2'b01)) fmt_err++;
      if (hs_aw && (m_awlen != 8'd7 || m_awsize != 3'd2 || m_awburst != 2'b01)) fmt_err++;
      if (hs_r && rserved == 1 && rbeat == 0) rb0_cyc = cyc;
      if (hs_w) begin
        if (m_wstrb != 4'hF || m_wlast != (wcnt == 7)) w_err++;
        if (wcnt == 0) w0_cyc = cyc;
        if (wcnt == 7) w7_cyc = cyc;
      end
      if (w_wait && (!m_wvalid || m_wdata != w_prev)) stab_err++;
      w_wait = m_wvalid && !m_wready;
      w_prev = m_wdata;
      if (hs_b) b_cyc = cyc;
    end
  end
  logic [31:0] m_araddr_q, m_awaddr_q, m_wdata_q;

  function automatic logic [31:0] elem(input logic [31:0] seed, input logic [31:0] step, input int i);
    return seed + step * 32'(i);
  endfunction

  function automatic logic [31:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    longint pa, pb, pf;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pf = pa * pb;
    return pf[31:0];
  endfunction

  task automatic run_case(input int k, input bit extra);
    logic [31:0] wa, wb, wr;
    int waited;
    wa = T_BA[k] & 32'hFFFF_FFFC;
    wb = T_BB[k] & 32'hFFFF_FFFC;
    wr = T_BR[k] & 32'hFFFF_FFFC;
    for (int i = 0; i < 8; i++) begin
      mem[((wa >> 2) + i) & 63] = elem(T_SA[k], T_DA[k], i);
      mem[((wb >> 2) + i) & 63] = elem(T_SB[k], T_DB[k], i);
      mem[((wr >> 2) + i) & 63] = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    model_clear();
    bp = T_BP[k];
    base_a = T_BA[k]; base_b = T_BB[k]; base_r = T_BR[k];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (4) @(negedge clk);
      base_a = 32'h10; base_b = 32'h14; base_r = 32'h18;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 3000) begin
      @(posedge clk);
      waited++;
    end
    chk(waited < 3000, "R8 watchdog", 32'(waited), 32'd3000);
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    chk(ar_log[0] == wa, "R1 A read address", ar_log[0], wa);
    chk(ar_log[1] == wb, "R1 B read address", ar_log[1], wb);
    chk(aw_log == wr, "R1 write address", aw_log, wr);
    chk(fmt_err == 0, "R2 burst fields", 32'(fmt_err), 32'd0);
    chk(ar_cnt == 2 && aw_cnt == 1, extra ? "R9 request count" : "R3 request count",
        32'(ar_cnt * 16 + aw_cnt), 32'h21);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = ref_prod(elem(T_SA[k], T_DA[k], i), elem(T_SB[k], T_DB[k], i));
      chk(mem[((wr >> 2) + i) & 63] == e, extra ? "R9 result word" : "R4 result word",
          mem[((wr >> 2) + i) & 63], e);
    end
    chk(w_err == 0 && wcnt == 8, "R5 strobes and last", 32'(w_err * 256 + wcnt), 32'd8);
    chk(stab_err == 0, "R7 held write data", 32'(stab_err), 32'd0);
    chk(done_cnt == 1, "R8 done width", 32'(done_cnt), 32'd1);
    chk(done_cyc - b_cyc == 1, "R8 done timing", 32'(done_cyc - b_cyc), 32'd1);
    if (!T_BP[k]) begin
      chk(w0_cyc - rb0_cyc == 3, "R6 product latency", 32'(w0_cyc - rb0_cyc), 32'd3);
      chk(w7_cyc - w0_cyc == 7, "R6 one beat per cycle", 32'(w7_cyc - w0_cyc), 32'd7);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk(!m_arvalid && !m_awvalid && !m_wvalid && !m_rready && !m_bready && !done,
        "R10 reset outputs",
        {26'd0, m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready, done}, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) run_case(k, 1'b0);
    run_case(0, 1'b1);
    run_case(2, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule